// File: doc/BRIEF.md
# Lane-Partitioned Adder-Subtractor with Carry

This block is a wide two-operand adder. At run time a boundary mask cuts it into independent lanes, at fixed eight-bit steps by default. Each cut stops the carry at that point. Each lane can add or subtract, and all lanes share one carry-in. Each lane reports its own carry-out. Subtraction has no circuit of its own. The B operand of the lane is inverted bitwise and a carry of one is fed into the bottom of the lane.

All lanes are computed by a single long adder. An extra bit sits in both operands at every possible cut point. A joined boundary sets that bit pair to (1, 0), which passes the carry upward. A cut boundary sets both bits to the carry-in of the lane above. This stops the carry from below and injects the new lane's own carry-in. The sum bit at the pair then equals the carry-out of the lane below. The output sum is the adder result with the extra bits taken out. The result can be registered at the output.

Top module: `simd_addsub`

## Requirements
- R1: Boundary bit `split_i[k]` set to 1 cuts the word between bits 8k+7 and 8k+8, and cleared to 0 joins the two sides. Each lane's `sum_o` field equals, modulo 2 to the lane width, A plus B (or plus the inverted B) plus the lane carry-in.
- R2: `inv_i[k]` belongs to eight-bit slice k, and 1 means invert B. In a lane built from several slices, only the bit of the lowest slice is used and the bits of the upper slices have no effect.
- R3: The carry-in of every lane is `cin_i` XOR the lane's invert setting. An adding lane therefore computes A+B+cin and a subtracting lane computes A-B-cin, with cin acting as the borrow.
- R4: `cout_o[k]` is the carry out of the top bit of the lane that ends at slice k. It is 0 for every slice that does not end a lane.
- R5: No carry crosses a cut boundary. A lane's result does not depend on any bit of the lanes below it.
- R6: Across joined boundaries the carry ripples through the whole lane. With no cuts, {`cout_o[7]`, `sum_o`} equals the 65-bit A+B+cin.
- R7: With REG_OUT=1, the outputs show the inputs of the previous rising clock edge. An active-low reset clears both outputs to zero.
- R8: Adding and subtracting lanes can be mixed in one operation, and each lane gets the result of its own operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Operand B |
| split_i | input | 7 | Boundary mask, 1 = cut above slice k |
| inv_i | input | 8 | Per-slice B-invert (subtract) control |
| cin_i | input | 1 | Carry-in shared by all lanes (borrow for subtracting lanes) |
| sum_o | output | 64 | Packed lane results |
| cout_o | output | 8 | Per-slice carry-out, valid at lane tops |

## Verification
At a cut boundary, two functions share the same bit pair in the same cycle. The pair must absorb the carry-out of the lane below and also start the carry-in of the lane above. The bench provokes this by driving operands that carry out of every lane, together with lane carry-ins of both values. It does this under all 128 boundary masks, with both operations and both carry-in values. Every output field and every carry-out bit is compared each cycle against a lane-by-lane bitwise model. An error in either function shows up as a wrong carry-out below the boundary or a wrong sum above it.

// File: rtl/simd_addsub_pkg.sv
package simd_addsub_pkg;

   // Bit index of data slice k inside the guard-extended operand.
   function automatic int slice_base(input int k, input int sw);
      return k * (sw + 1);
   endfunction

   // Bit index of the guard bit sitting above slice k.
   function automatic int guard_pos(input int k, input int sw);
      return k * (sw + 1) + sw;
   endfunction

endpackage

// File: rtl/simd_lane_ctrl.sv
module simd_lane_ctrl #(
   parameter int NUM_SLICES = 8
) (
   input  logic [NUM_SLICES-2:0] split_i,
   input  logic [NUM_SLICES-1:0] inv_i,
   input  logic                  cin_i,
   output logic [NUM_SLICES-1:0] eff_inv_o,
   output logic [NUM_SLICES-1:0] lane_cin_o,
   output logic [NUM_SLICES-1:0] lane_end_o
);

   // Each slice inherits the invert setting of the lowest slice of its lane.
   assign eff_inv_o[0] = inv_i[0];

   for (genvar k = 1; k < NUM_SLICES; k++) begin : g_inherit
      assign eff_inv_o[k] = split_i[k-1] ? inv_i[k] : eff_inv_o[k-1];
   end

   for (genvar k = 0; k < NUM_SLICES; k++) begin : g_lane
      assign lane_cin_o[k] = cin_i ^ eff_inv_o[k];
      if (k == NUM_SLICES - 1) begin : g_top
         assign lane_end_o[k] = 1'b1;
      end else begin : g_mid
         assign lane_end_o[k] = split_i[k];
      end
   end

endmodule

// File: rtl/simd_guard_pack.sv
module simd_guard_pack
   import simd_addsub_pkg::*;
#(
   parameter int SLICE_W    = 8,
   parameter int NUM_SLICES = 8,
   localparam int W  = SLICE_W * NUM_SLICES,
   localparam int AW = W + NUM_SLICES - 1
) (
   input  logic [W-1:0]          a_i,
   input  logic [W-1:0]          b_i,
   input  logic [NUM_SLICES-2:0] split_i,
   input  logic [NUM_SLICES-1:0] eff_inv_i,
   input  logic [NUM_SLICES-1:0] lane_cin_i,
   output logic [AW-1:0]         ext_a_o,
   output logic [AW-1:0]         ext_b_o
);

   for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
      localparam int BASE = slice_base(k, SLICE_W);
      assign ext_a_o[BASE +: SLICE_W] = a_i[k*SLICE_W +: SLICE_W];
      assign ext_b_o[BASE +: SLICE_W] = b_i[k*SLICE_W +: SLICE_W]
                                        ^ {SLICE_W{eff_inv_i[k]}};
      if (k < NUM_SLICES - 1) begin : g_guard
         localparam int GP = guard_pos(k, SLICE_W);
         // joined: (1,0) propagates; cut: (c,c) kills or injects
         assign ext_a_o[GP] = split_i[k] ? lane_cin_i[k+1] : 1'b1;
         assign ext_b_o[GP] = split_i[k] ? lane_cin_i[k+1] : 1'b0;
      end
   end

endmodule

// File: rtl/simd_guard_unpack.sv
module simd_guard_unpack
   import simd_addsub_pkg::*;
#(
   parameter int SLICE_W    = 8,
   parameter int NUM_SLICES = 8,
   localparam int W  = SLICE_W * NUM_SLICES,
   localparam int AW = W + NUM_SLICES - 1
) (
   input  logic [AW:0]           ext_sum_i,
   input  logic [NUM_SLICES-1:0] lane_end_i,
   output logic [W-1:0]          sum_o,
   output logic [NUM_SLICES-1:0] cout_o
);

   for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
      localparam int BASE = slice_base(k, SLICE_W);
      assign sum_o[k*SLICE_W +: SLICE_W] = ext_sum_i[BASE +: SLICE_W];
      if (k == NUM_SLICES - 1) begin : g_top
         assign cout_o[k] = ext_sum_i[AW];
      end else begin : g_mid
         // guard pair is (c,c) when cut, so its sum bit is the carry from below
         assign cout_o[k] = lane_end_i[k] & ext_sum_i[guard_pos(k, SLICE_W)];
      end
   end

endmodule

// File: rtl/simd_addsub.sv
module simd_addsub #(
   parameter int SLICE_W    = 8,
   parameter int NUM_SLICES = 8,
   parameter bit REG_OUT    = 1'b1
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic [SLICE_W*NUM_SLICES-1:0] a_i,
   input  logic [SLICE_W*NUM_SLICES-1:0] b_i,
   input  logic [NUM_SLICES-2:0]         split_i,
   input  logic [NUM_SLICES-1:0]         inv_i,
   input  logic                          cin_i,
   output logic [SLICE_W*NUM_SLICES-1:0] sum_o,
   output logic [NUM_SLICES-1:0]         cout_o
);

   localparam int W  = SLICE_W * NUM_SLICES;
   localparam int AW = W + NUM_SLICES - 1;

   if (SLICE_W < 1 || NUM_SLICES < 2) begin : g_bad_param
      $error("simd_addsub: SLICE_W must be >= 1 and NUM_SLICES >= 2");
   end

   logic [NUM_SLICES-1:0] eff_inv, lane_cin, lane_end;
   logic [AW-1:0]         ext_a, ext_b;
   logic [AW:0]           ext_sum;
   logic [W-1:0]          sum_c;
   logic [NUM_SLICES-1:0] cout_c;

   simd_lane_ctrl #(.NUM_SLICES(NUM_SLICES)) u_ctrl (
      .split_i   (split_i),
      .inv_i     (inv_i),
      .cin_i     (cin_i),
      .eff_inv_o (eff_inv),
      .lane_cin_o(lane_cin),
      .lane_end_o(lane_end)
   );

   simd_guard_pack #(.SLICE_W(SLICE_W), .NUM_SLICES(NUM_SLICES)) u_pack (
      .a_i       (a_i),
      .b_i       (b_i),
      .split_i   (split_i),
      .eff_inv_i (eff_inv),
      .lane_cin_i(lane_cin),
      .ext_a_o   (ext_a),
      .ext_b_o   (ext_b)
   );

   // One long adder; the lowest lane's carry-in enters as the carry term.
   assign ext_sum = {1'b0, ext_a} + {1'b0, ext_b} + {{AW{1'b0}}, lane_cin[0]};

   simd_guard_unpack #(.SLICE_W(SLICE_W), .NUM_SLICES(NUM_SLICES)) u_unpack (
      .ext_sum_i (ext_sum),
      .lane_end_i(lane_end),
      .sum_o     (sum_c),
      .cout_o    (cout_c)
   );

   if (REG_OUT) begin : g_reg
      logic live_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            sum_o  <= '0;
            cout_o <= '0;
            live_q <= 1'b0;
         end else begin
            sum_o  <= sum_c;
            cout_o <= cout_c;
            live_q <= 1'b1;
         end
      end

      // R6: with no cuts the word behaves as one full-width add
      p_full_width_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || !live_q)
         ($past(split_i) == '0 && !$past(inv_i[0]))
         |-> ({cout_o[NUM_SLICES-1], sum_o} ==
              {1'b0, $past(a_i)} + {1'b0, $past(b_i)} + (W+1)'($past(cin_i))));

      // R1: adding zero with no carry returns A and no carry-out anywhere
      p_add_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni || !live_q)
         ($past(b_i) == '0 && $past(inv_i) == '0 && !$past(cin_i))
         |-> (sum_o == $past(a_i) && cout_o == '0));

      // R3: a lone lowest lane subtracting equal values gives zero, carry 1
      p_zero_diff_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || !live_q)
         ($past(split_i[0]) && $past(inv_i[0]) && !$past(cin_i) &&
          $past(a_i[SLICE_W-1:0]) == $past(b_i[SLICE_W-1:0]))
         |-> (sum_o[SLICE_W-1:0] == '0 && cout_o[0]));

      for (genvar k = 0; k < NUM_SLICES - 1; k++) begin : g_chk
         // R4: slices inside a lane report no carry-out
         p_cout_lane_end_r4: assert property (@(posedge clk_i)
            disable iff (!rst_ni || !live_q)
            !$past(split_i[k]) |-> !cout_o[k]);
      end
   end else begin : g_comb
      assign sum_o  = sum_c;
      assign cout_o = cout_c;
   end

endmodule

// File: tb/simd_addsub_tb.sv
module simd_addsub_tb_top;

   localparam int SW = 8;
   localparam int N  = 8;
   localparam int W  = SW * N;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] a = '0, b = '0;
   logic [N-2:0] split = '0;
   logic [N-1:0] inv = '0;
   logic         cin = 1'b0;
   logic [W-1:0] sum;
   logic [N-1:0] cout;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   simd_addsub #(.SLICE_W(SW), .NUM_SLICES(N), .REG_OUT(1'b1)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .split_i(split),
      .inv_i(inv), .cin_i(cin), .sum_o(sum), .cout_o(cout)
   );

   // Behavioural reference: walk the word lane by lane, bit by bit.
   function automatic void model(input logic [W-1:0] ma, input logic [W-1:0] mb,
                                 input logic [N-2:0] ms, input logic [N-1:0] mi,
                                 input logic mc, output logic [W-1:0] es,
                                 output logic [N-1:0] ec);
      int lo = 0;
      es = '0;
      ec = '0;
      for (int s = 0; s < N; s++) begin
         if (s == N - 1 || ms[s]) begin
            logic inv_l = mi[lo];
            logic c = mc ^ inv_l;
            for (int i = lo * SW; i < (s + 1) * SW; i++) begin
               logic bb = mb[i] ^ inv_l;
               es[i] = ma[i] ^ bb ^ c;
               c = (ma[i] & bb) | (ma[i] & c) | (bb & c);
            end
            ec[s] = c;
            lo = s + 1;
         end
      end
   endfunction

   task automatic check(input string req, input logic [W-1:0] es,
                        input logic [N-1:0] ec);
      checks++;
      if (sum !== es) begin
         errors++;
         $display("FAIL %s sum: actual %h expected %h", req, sum, es);
      end
      checks++;
      if (cout !== ec) begin
         errors++;
         $display("FAIL %s cout: actual %b expected %b", req, cout, ec);
      end
   endtask

   // Called at a falling edge; result appears after the next rising edge.
   task automatic run(input string req, input logic [W-1:0] ta, input logic [W-1:0] tb,
                      input logic [N-2:0] ts, input logic [N-1:0] ti, input logic tc);
      logic [W-1:0] es;
      logic [N-1:0] ec;
      a = ta; b = tb; split = ts; inv = ti; cin = tc;
      model(ta, tb, ts, ti, tc, es, ec);
      @(negedge clk);
      check(req, es, ec);
   endtask

   function automatic logic [W-1:0] rnd64();
      return {$urandom(), $urandom()};
   endfunction

   initial begin
      #(2_000_000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R7 reset", '0, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R6: full ripple through a joined word
      run("R6", '1, 64'd1, '0, '0, 1'b0);
      run("R6 cin", '1, '0, '0, '0, 1'b1);
      // R5: carry stopped at every cut
      run("R5", '1, 64'h0101_0101_0101_0101, '1, '0, 1'b0);
      run("R5 low", '1, 64'd1, '1, '0, 1'b0);
      // R3: borrow on subtracting lanes, carry on adding lanes
      run("R3 borrow", 64'h1234_5678_9abc_def0, 64'h1234_5678_9abc_def0, '1, '1, 1'b1);
      run("R3 carry", 64'h0f0f_0f0f_0f0f_0f0f, 64'h0101_0101_0101_0101, '1, '0, 1'b1);
      // R2: upper slice invert bits ignored in a joined lane
      run("R2 a", 64'h0000_0000_0000_0100, 64'd1, '0, 8'h01, 1'b0);
      run("R2 b", 64'h0000_0000_0000_0100, 64'd1, '0, 8'hFF, 1'b0);
      run("R2 c", 64'h0000_0000_0000_0100, 64'd1, 7'b1111110, 8'b0000_0010, 1'b0);
      // R8: mixed operations in one word
      run("R8", rnd64(), rnd64(), '1, 8'b1010_1010, 1'b0);
      run("R8 pairs", rnd64(), rnd64(), 7'b1010101, 8'b0011_0100, 1'b1);

      // R1/R4: every boundary mask with several operand patterns
      for (int m = 0; m < (1 << (N - 1)); m++) begin
         run("R1", rnd64(), rnd64(), m[N-2:0], '0, 1'b0);
         run("R4", '1, '1, m[N-2:0], 8'($urandom()), 1'($urandom()));
         run("R4 sub", rnd64(), rnd64(), m[N-2:0], '1, 1'b0);
         run("R1 rnd", rnd64(), rnd64(), m[N-2:0], 8'($urandom()), 1'($urandom()));
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule